// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block is the interrupt front end of one GPIO bank. Every pin carries three configuration bits (detect kind, active sense and dual-edge) that choose rising-edge, falling-edge, both-edge, high-level or low-level detection. Detected events are latched into a per-pin pending register, which software clears by writing ones. A separate mask decides which pending pins reach the single interrupt output.

Detection never stops. A masked pin keeps collecting events, and masking only blocks the path to the interrupt output. The mask is changed only through two write-only strobe registers, one that sets mask bits and one that clears them. Software can read it back through a read-only view. Pin levels arrive already synchronized. The register port is a single-cycle write strobe with a combinational read.

Top module: `gpio_irq_bank`

## Requirements
- R1: Reset state:
  - kind, sense, dual-edge and pending all read 0.
  - The mask reads all ones, so every pin is masked.
  - `irq_o` is low.
  - The previous-level history of every pin is 0.
- R2: Configuration registers read back what was written:
  - Word 0 is kind (1 = edge, 0 = level).
  - Word 1 is sense (1 = rising or high, 0 = falling or low).
  - Word 2 is dual-edge.
- R3: Edge kind with sense 1 and dual-edge 0 latches a pending bit only on a 0-to-1 change of the pin.
- R4: Edge kind with sense 0 and dual-edge 0 latches a pending bit only on a 1-to-0 change.
- R5: Edge kind with dual-edge 1 latches on either change, whatever the sense bit holds.
- R6: Level kind behaves as follows:
  - The pending bit is set on every cycle in which the pin matches the sense. Sense 1 is active high and sense 0 is active low.
  - The dual-edge bit has no effect.
  - A clear has no lasting effect while the level persists.
- R7: Writing word 6 (pending) clears each bit written as 1. Bits written as 0 are left unchanged.
- R8: Mask access:
  - Writing ones to word 3 unmasks those pins.
  - Writing ones to word 4 masks them.
  - Zero bits have no effect on either word.
  - Word 5 reads the mask, with 1 meaning masked.
  - Words 3 and 4 read as 0.
- R9: `irq_o` is high exactly when some pending bit is set whose mask bit is 0.
- R10: Events latch while a pin is masked. Unmasking a pin with a pending bit raises `irq_o` in the cycle after the write.
- R11: When a clear and a new event for the same pin fall in the same cycle, the pin stays pending.
- R12: Edge detection compares the sampled level with the level sampled on the previous cycle. A pin held steady after an edge does not set the pending bit again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Synchronized pin levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word select |
| reg_wdata_i | input | NPINS | Register write data |
| reg_rdata_o | output | NPINS | Register read data (combinational) |
| irq_o | output | 1 | Bank interrupt request |

## Verification
The hardest case to reach is a clear and a fresh edge arriving in the same cycle. The bench reaches it by driving the pending-clear write and the pin change on the same falling clock edge, after holding the pin steady long enough to settle the history register.

The other delicate case is an event caught while masked and released later. It is reached by raising a pin with the mask full, unmasking an unrelated pin first, and only then unmasking the pending one.

Every detection mode is swept over pairs of before and after levels. The expected pending word is computed arithmetically from the mode bits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned SEL_W = 3;
  typedef enum logic [SEL_W-1:0] {
    SEL_KIND = 3'd0,
    SEL_SENS = 3'd1,
    SEL_DUAL = 3'd2,
    SEL_UNMK = 3'd3,
    SEL_MASK_SET = 3'd4,
    SEL_MASK = 3'd5,
    SEL_PEND = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  reg_sel_e         sel_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] kind_o,
  output logic [NPINS-1:0] sens_o,
  output logic [NPINS-1:0] dual_o,
  output logic [NPINS-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o <= '0;
      sens_o <= '0;
      dual_o <= '0;
      mask_o <= '1;
    end else if (we_i) begin
      case (sel_i)
        SEL_KIND:     kind_o <= wdata_i;
        SEL_SENS:     sens_o <= wdata_i;
        SEL_DUAL:     dual_o <= wdata_i;
        SEL_UNMK:     mask_o <= mask_o & ~wdata_i;
        SEL_MASK_SET: mask_o <= mask_o | wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] kind_i,
  input  logic [NPINS-1:0] sens_i,
  input  logic [NPINS-1:0] dual_i,
  output logic [NPINS-1:0] event_o
);
  logic [NPINS-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= pin_i;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, lvl_hit, edg_hit;
    assign rise    = pin_i[i] & ~hist_q[i];
    assign fall    = ~pin_i[i] & hist_q[i];
    assign lvl_hit = ~(pin_i[i] ^ sens_i[i]);
    assign edg_hit = dual_i[i] ? (rise | fall) : (sens_i[i] ? rise : fall);
    assign event_o[i] = kind_i[i] ? edg_hit : lvl_hit;
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] event_i,
  input  logic [NPINS-1:0] clr_i,
  input  logic [NPINS-1:0] mask_i,
  output logic [NPINS-1:0] pend_o,
  output logic             irq_o
);
  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_i) | event_i;
  end

  assign irq_o = |(pend_o & ~mask_i);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [NPINS-1:0] reg_wdata_i,
  output logic [NPINS-1:0] reg_rdata_o,
  output logic             irq_o
);
  reg_sel_e         sel;
  logic [NPINS-1:0] kind_w, sens_w, dual_w, mask_w, pend_w, event_w, clr_w;

  assign sel   = reg_sel_e'(reg_addr_i);
  assign clr_w = (reg_we_i && sel == SEL_PEND) ? reg_wdata_i : '0;

  gpio_irq_cfg #(.NPINS(NPINS)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .sel_i(sel),
    .wdata_i(reg_wdata_i), .kind_o(kind_w), .sens_o(sens_w),
    .dual_o(dual_w), .mask_o(mask_w)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .kind_i(kind_w),
    .sens_i(sens_w), .dual_i(dual_w), .event_o(event_w)
  );

  gpio_irq_status #(.NPINS(NPINS)) u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .event_i(event_w), .clr_i(clr_w),
    .mask_i(mask_w), .pend_o(pend_w), .irq_o(irq_o)
  );

  always_comb begin
    case (sel)
      SEL_KIND: reg_rdata_o = kind_w;
      SEL_SENS: reg_rdata_o = sens_w;
      SEL_DUAL: reg_rdata_o = dual_w;
      SEL_MASK: reg_rdata_o = mask_w;
      SEL_PEND: reg_rdata_o = pend_w;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic [NPINS-1:0] reg_wdata_i,
  input logic [NPINS-1:0] mask_i,
  input logic [NPINS-1:0] pend_i,
  input logic [NPINS-1:0] event_i,
  input logic             irq_i
);
  logic wr_unmk, wr_mset, wr_pend;
  assign wr_unmk = reg_we_i && reg_addr_i == SEL_UNMK;
  assign wr_mset = reg_we_i && reg_addr_i == SEL_MASK_SET;
  assign wr_pend = reg_we_i && reg_addr_i == SEL_PEND;

  p_unmask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_unmk |=> (mask_i & $past(reg_wdata_i)) == '0);

  p_mask_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mset |=> (mask_i & $past(reg_wdata_i)) == $past(reg_wdata_i));

  p_mask_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_unmk || wr_mset) |=> $stable(mask_i));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pend |=> (pend_i & $past(reg_wdata_i) & ~$past(event_i)) == '0);

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pend |=> (pend_i & $past(pend_i)) == $past(pend_i));

  p_event_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_i & $past(event_i)) == $past(event_i));

  p_masked_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !irq_i);

  p_irq_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (pend_i != '0));

  p_unmask_pending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_unmk && (pend_i & reg_wdata_i) != '0) |=> irq_i);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .mask_i(mask_w),
  .pend_i(pend_w), .event_i(event_w), .irq_i(irq_o)
);

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
  localparam int unsigned N = 8;
  localparam logic [2:0] A_KIND = 3'd0, A_SENS = 3'd1, A_DUAL = 3'd2,
                         A_UNMK = 3'd3, A_MSET = 3'd4, A_MASK = 3'd5,
                         A_PEND = 3'd6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0;
  logic         we = 1'b0;
  logic [2:0]   addr = A_PEND;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq;
  int           n_chk = 0;
  int           n_err = 0;
  bit           done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.NPINS(N)) u_gpio_irq_bank (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    addr = a;
    #0.1;
    v = rdata;
  endtask

  function automatic logic [N-1:0] ev(input logic [N-1:0] prv, input logic [N-1:0] cur,
                                      input bit k, input bit s, input bit d);
    if (!k) return s ? cur : ~cur;
    if (d)  return prv ^ cur;
    return s ? (cur & ~prv) : (prv & ~cur);
  endfunction

  task automatic set_mode(input bit k, input bit s, input bit d);
    wr(A_KIND, k ? '1 : '0);
    wr(A_SENS, s ? '1 : '0);
    wr(A_DUAL, d ? '1 : '0);
  endtask

  initial begin
    logic [N-1:0] v;
    bit mk [7], ms [7], md [7];
    string mreq [7];
    mk = '{1,1,1,1,0,0,0};
    ms = '{1,0,0,1,1,0,1};
    md = '{0,0,1,1,0,0,1};
    mreq = '{"R3 rise", "R4 fall", "R5 dual s0", "R5 dual s1",
             "R6 high", "R6 low", "R6 high dual"};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(A_PEND, v); chk("R1 pending", v, '0);
    chk("R1 irq", {{(N-1){1'b0}}, irq}, '0);
    rd(A_MASK, v); chk("R1 mask", v, '1);
    rd(A_KIND, v); chk("R1 kind", v, '0);
    rd(A_SENS, v); chk("R1 sense", v, '0);
    rd(A_DUAL, v); chk("R1 dual", v, '0);
    @(negedge clk);
    rd(A_PEND, v); chk("R6 default low level", v, '1);

    wr(A_KIND, 8'hA5); wr(A_SENS, 8'h3C); wr(A_DUAL, 8'h96);
    rd(A_KIND, v); chk("R2 kind", v, 8'hA5);
    rd(A_SENS, v); chk("R2 sense", v, 8'h3C);
    rd(A_DUAL, v); chk("R2 dual", v, 8'h96);

    wr(A_UNMK, 8'h0F); rd(A_MASK, v); chk("R8 unmask", v, 8'hF0);
    wr(A_UNMK, 8'h00); rd(A_MASK, v); chk("R8 unmask zero", v, 8'hF0);
    wr(A_MSET, 8'h03); rd(A_MASK, v); chk("R8 mask set", v, 8'hF3);
    wr(A_MSET, 8'h00); rd(A_MASK, v); chk("R8 mask set zero", v, 8'hF3);
    rd(A_UNMK, v); chk("R8 unmask word reads 0", v, '0);
    rd(A_MSET, v); chk("R8 mask-set word reads 0", v, '0);
    wr(A_MSET, 8'hFF); rd(A_MASK, v); chk("R8 mask all", v, '1);

    // sweep every mode over pairs of before/after levels
    for (int m = 0; m < 7; m++) begin
      set_mode(mk[m], ms[m], md[m]);
      for (int j = 0; j < 16; j++) begin
        logic [N-1:0] a, b;
        a = N'(j * 37 + 3);
        b = N'(j * 91 + 5);
        if (j == 15) b = a;
        pin = a;
        @(negedge clk); @(negedge clk);
        wr(A_PEND, '1);
        pin = b;
        @(negedge clk);
        rd(A_PEND, v);
        chk(mreq[m], v, ev(a, a, mk[m], ms[m], md[m]) | ev(a, b, mk[m], ms[m], md[m]));
        chk("R9 masked irq", {{(N-1){1'b0}}, irq}, '0);
      end
    end

    // R12: rising edge then held high does not retrigger
    set_mode(1, 1, 0);
    pin = '0; @(negedge clk); @(negedge clk);
    wr(A_PEND, '1);
    pin = 8'h01; @(negedge clk); @(negedge clk);
    wr(A_PEND, '1);
    @(negedge clk);
    rd(A_PEND, v); chk("R12 steady high no retrigger", v, '0);

    // R11: clear and new edge in one cycle
    pin = '0; @(negedge clk); @(negedge clk);
    wr(A_PEND, '1);
    @(negedge clk);
    we = 1'b1; addr = A_PEND; wdata = '1; pin = 8'h10;
    @(negedge clk);
    we = 1'b0;
    rd(A_PEND, v); chk("R11 event beats clear", v, 8'h10);

    // R10/R9/R7: latch while masked, release on unmask
    wr(A_PEND, '1);
    pin = 8'h18; @(negedge clk);
    rd(A_PEND, v); chk("R10 latched while masked", v, 8'h08);
    chk("R10 irq held back", {{(N-1){1'b0}}, irq}, '0);
    wr(A_UNMK, 8'h04);
    chk("R9 unmasked pin idle", {{(N-1){1'b0}}, irq}, '0);
    wr(A_UNMK, 8'h08);
    chk("R10 irq on unmask", {{(N-1){1'b0}}, irq}, 8'h01);
    wr(A_PEND, 8'h00);
    rd(A_PEND, v); chk("R7 zero write keeps pending", v, 8'h08);
    wr(A_PEND, 8'h08);
    rd(A_PEND, v); chk("R7 clear", v, '0);
    chk("R9 irq drops after clear", {{(N-1){1'b0}}, irq}, '0);

    // R6: level clear has no lasting effect
    set_mode(0, 1, 0);
    pin = 8'hC3; @(negedge clk);
    wr(A_PEND, '1); @(negedge clk);
    rd(A_PEND, v); chk("R6 level persists through clear", v, 8'hC3);
    wr(A_MSET, '1);
    chk("R9 full mask quiets irq", {{(N-1){1'b0}}, irq}, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule